// File: doc/BRIEF.md
# Paged Memory Write Router

This block sits between an 8-bit processor core and a 64 KiB address space. It sends every processor access either to a RAM port or to a memory-mapped I/O port. Addresses whose top nibble is 0xC form the I/O window. Within that window, bits [11:4] of the address select one of 256 handler slots.

Reads are never translated: they reach RAM at the address the core issued, or they reach the I/O slot. Writes are looked up in a 256-entry page table, with one entry per 256-byte page, which software loads through a separate configuration port.
- A valid entry redirects the write to its target physical page.
- An invalid entry inside the I/O window turns the write into an I/O write.
- An invalid entry anywhere else discards the write, so that page behaves like ROM.

Every write marks its source page in a 256-bit dirty bitmap, whether or not the write lands. The bitmap can be cleared synchronously. All port outputs are registered, and read data returns through one registered mux, so RAM reads and I/O reads have the same latency.

Top module: `pmr_router`

## Requirements
- R1: While `rst` is high and on the first cycle after it: `ram_re`, `ram_we`, `io_stb`, `io_rd`, `io_wr`, `cpu_rvalid` are 0 and `dirty` is all zeros. After reset every page-table entry is invalid.
- R2: An address is in the I/O window when `cpu_addr[15:12] == 4'hC`. A read there produces an I/O read with `io_slot = cpu_addr[11:4]`. Any other read produces a RAM read at `ram_addr = cpu_addr`, unchanged.
- R3: A write to a page whose table entry is valid produces a RAM write at `ram_addr = {target, cpu_addr[7:0]}` with `ram_wdata = cpu_wdata`. This holds inside the I/O window too.
- R4: A write to an invalid page inside the I/O window produces an I/O write with `io_slot = cpu_addr[11:4]` and `io_wdata = cpu_wdata`.
- R5: A write to an invalid page outside the I/O window asserts none of `ram_we`, `ram_re` or `io_stb`.
- R6: Every write sets `dirty[cpu_addr[15:8]]`, visible the cycle after the write, including writes that are discarded. Reads set no bit. A bit only returns to 0 through `dirty_clr`.
- R7: `dirty_clr` zeroes the whole bitmap on the next cycle. If a write arrives in the same cycle, that write's page bit ends up set.
- R8: Port strobes are registered. They appear in the cycle after the core's request and last one cycle per request. `io_stb` is always accompanied by exactly one of `io_rd` or `io_wr`, and never coincides with `ram_re` or `ram_we`.
- R9: For both RAM and I/O reads, `cpu_rvalid` pulses two cycles after `cpu_rd`. `cpu_rdata` carries the `ram_rdata` or `io_rdata` value presented in the port cycle.
- R10: When `cfg_we` is high, the entry for page `cfg_page` takes the valid bit `cfg_valid` and the target `cfg_target`. A core write to that page in the same cycle still uses the previous entry.
- R11: When `cpu_rd` and `cpu_wr` are both high, only the write is performed: no read strobe and no `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Core address |
| cpu_wdata | input | 8 | Core write data |
| cpu_rd | input | 1 | Core read request |
| cpu_wr | input | 1 | Core write request |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cfg_we | input | 1 | Page-table entry write enable |
| cfg_page | input | 8 | Page-table entry index |
| cfg_valid | input | 1 | Valid bit for the entry |
| cfg_target | input | 8 | Target physical page for the entry |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the strobe cycle |
| io_stb | output | 1 | I/O access strobe |
| io_rd | output | 1 | I/O read qualifier |
| io_wr | output | 1 | I/O write qualifier |
| io_slot | output | 8 | I/O handler slot index |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, valid in the strobe cycle |
| dirty_clr | input | 1 | Clear the dirty bitmap |
| dirty | output | 256 | Per-page dirty bitmap |

## Verification
The assertions check the following on every cycle:
- the I/O qualifier pairing and the exclusion of RAM and I/O strobes against each other;
- that a write always leaves its page's dirty bit set;
- that dirty bits never drop except after a clear;
- the two-cycle read response and write-over-read priority.

Some behaviours depend on the table contents and on the expected addresses and data, so only the bench scenarios can show them:
- the remapped RAM address;
- the choice between I/O write and silent discard;
- read-before-write on a simultaneous configuration write;
- a clear racing a write.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic [2:0] {
    RT_NONE   = 3'd0,
    RT_RAM_RD = 3'd1,
    RT_RAM_WR = 3'd2,
    RT_IO_RD  = 3'd3,
    RT_IO_WR  = 3'd4
  } rt_kind_e;

endpackage

// File: rtl/pmr_map_table.sv
module pmr_map_table #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_valid,
  input  logic [PAGE_W-1:0] cfg_target,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              lk_hit,
  output logic [PAGE_W-1:0] lk_target
);
  localparam int N_PAGES = 1 << PAGE_W;

  // Targets: no reset, so the storage maps onto RAM primitives.
  logic [PAGE_W-1:0] tgt_mem [N_PAGES];
  // Valid bits: flops, so that reset invalidates every page at once.
  logic [N_PAGES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (cfg_we) tgt_mem[cfg_page] <= cfg_target;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (cfg_we) vld_q[cfg_page] <= cfg_valid;
  end

  // Asynchronous read: a same-cycle config write is seen only next cycle.
  assign lk_hit    = vld_q[lk_page];
  assign lk_target = tgt_mem[lk_page];

endmodule

// File: rtl/pmr_dirty_map.sv
module pmr_dirty_map #(
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_en,
  input  logic [PAGE_W-1:0]        set_idx,
  input  logic                     clr,
  output logic [(1<<PAGE_W)-1:0]   bits
);
  localparam int N_PAGES = 1 << PAGE_W;

  logic [N_PAGES-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = clr ? '0 : bits_q;
    if (set_en) bits_d[set_idx] = 1'b1;   // set beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_d;
  end

  assign bits = bits_q;

endmodule

// File: rtl/pmr_route.sv
module pmr_route
  import pmr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          OFF_W    = 8,
  parameter int          IO_TAG_W = 4,
  parameter int unsigned IO_TAG   = 12,
  parameter int          SLOT_W   = 8
) (
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic                     map_hit,
  input  logic [ADDR_W-OFF_W-1:0]  map_target,
  output rt_kind_e                 kind,
  output logic [ADDR_W-1:0]        phys_addr,
  output logic [SLOT_W-1:0]        slot
);
  localparam int SLOT_LSB = ADDR_W - IO_TAG_W - SLOT_W;
  localparam logic [IO_TAG_W-1:0] IO_TAG_V = IO_TAG[IO_TAG_W-1:0];

  logic in_io;

  always_comb begin
    in_io     = (cpu_addr[ADDR_W-1 -: IO_TAG_W] == IO_TAG_V);
    slot      = cpu_addr[SLOT_LSB +: SLOT_W];
    phys_addr = cpu_addr;
    kind      = RT_NONE;
    if (cpu_wr) begin
      if (map_hit) begin
        kind      = RT_RAM_WR;
        phys_addr = {map_target, cpu_addr[OFF_W-1:0]};
      end else if (in_io) begin
        kind = RT_IO_WR;
      end
      // otherwise the write is discarded (read-only page)
    end else if (cpu_rd) begin
      kind = in_io ? RT_IO_RD : RT_RAM_RD;
    end
  end

endmodule

// File: rtl/pmr_rdata_mux.sv
module pmr_rdata_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_sel,
  input  logic              io_sel,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= ram_sel | io_sel;
      if (ram_sel)     rdata <= ram_rdata;
      else if (io_sel) rdata <= io_rdata;
    end
  end

endmodule

// File: rtl/pmr_router.sv
module pmr_router
  import pmr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          OFF_W    = 8,
  parameter int          IO_TAG_W = 4,
  parameter int unsigned IO_TAG   = 12,
  parameter int          SLOT_W   = 8,
  localparam int         PAGE_W   = ADDR_W - OFF_W,
  localparam int         N_PAGES  = 1 << PAGE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_rvalid,
  input  logic               cfg_we,
  input  logic [PAGE_W-1:0]  cfg_page,
  input  logic               cfg_valid,
  input  logic [PAGE_W-1:0]  cfg_target,
  output logic               ram_re,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               io_stb,
  output logic               io_rd,
  output logic               io_wr,
  output logic [SLOT_W-1:0]  io_slot,
  output logic [DATA_W-1:0]  io_wdata,
  input  logic [DATA_W-1:0]  io_rdata,
  input  logic               dirty_clr,
  output logic [N_PAGES-1:0] dirty
);
  logic [PAGE_W-1:0] src_page;
  logic              map_hit;
  logic [PAGE_W-1:0] map_target;
  rt_kind_e          kind;
  logic [ADDR_W-1:0] phys_addr;
  logic [SLOT_W-1:0] slot;

  assign src_page = cpu_addr[ADDR_W-1 -: PAGE_W];

  pmr_map_table #(.PAGE_W(PAGE_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_page  (cfg_page),
    .cfg_valid (cfg_valid),
    .cfg_target(cfg_target),
    .lk_page   (src_page),
    .lk_hit    (map_hit),
    .lk_target (map_target)
  );

  pmr_dirty_map #(.PAGE_W(PAGE_W)) u_dirty (
    .clk    (clk),
    .rst    (rst),
    .set_en (cpu_wr),
    .set_idx(src_page),
    .clr    (dirty_clr),
    .bits   (dirty)
  );

  pmr_route #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .IO_TAG_W(IO_TAG_W),
    .IO_TAG  (IO_TAG),
    .SLOT_W  (SLOT_W)
  ) u_route (
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .map_hit   (map_hit),
    .map_target(map_target),
    .kind      (kind),
    .phys_addr (phys_addr),
    .slot      (slot)
  );

  // Registered port stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_re    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      io_stb    <= 1'b0;
      io_rd     <= 1'b0;
      io_wr     <= 1'b0;
      io_slot   <= '0;
      io_wdata  <= '0;
    end else begin
      ram_re    <= (kind == RT_RAM_RD);
      ram_we    <= (kind == RT_RAM_WR);
      ram_addr  <= phys_addr;
      ram_wdata <= cpu_wdata;
      io_stb    <= (kind == RT_IO_RD) || (kind == RT_IO_WR);
      io_rd     <= (kind == RT_IO_RD);
      io_wr     <= (kind == RT_IO_WR);
      io_slot   <= slot;
      io_wdata  <= cpu_wdata;
    end
  end

  pmr_rdata_mux #(.DATA_W(DATA_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .ram_sel  (ram_re),
    .io_sel   (io_stb & io_rd),
    .ram_rdata(ram_rdata),
    .io_rdata (io_rdata),
    .rdata    (cpu_rdata),
    .rvalid   (cpu_rvalid)
  );

endmodule

// File: rtl/pmr_router_chk.sv
module pmr_router_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          OFF_W    = 8,
  parameter int          IO_TAG_W = 4,
  parameter int unsigned IO_TAG   = 12,
  parameter int          SLOT_W   = 8,
  localparam int         PAGE_W   = ADDR_W - OFF_W,
  localparam int         N_PAGES  = 1 << PAGE_W
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic               cpu_rvalid,
  input logic               ram_re,
  input logic               ram_we,
  input logic               io_stb,
  input logic               io_rd,
  input logic               io_wr,
  input logic [SLOT_W-1:0]  io_slot,
  input logic               dirty_clr,
  input logic [N_PAGES-1:0] dirty
);
  localparam int SLOT_LSB = ADDR_W - IO_TAG_W - SLOT_W;
  localparam logic [IO_TAG_W-1:0] IO_TAG_V = IO_TAG[IO_TAG_W-1:0];

  logic              past_ok;
  logic [PAGE_W-1:0] wr_page;
  logic              in_io;
  logic [SLOT_W-1:0] req_slot;

  assign wr_page  = cpu_addr[ADDR_W-1 -: PAGE_W];
  assign in_io    = (cpu_addr[ADDR_W-1 -: IO_TAG_W] == IO_TAG_V);
  assign req_slot = cpu_addr[SLOT_LSB +: SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r8_io_qualified: assert property (@(posedge clk) disable iff (rst)
    io_stb |-> (io_rd ^ io_wr));

  a_r8_no_stray_qualifier: assert property (@(posedge clk) disable iff (rst)
    !io_stb |-> !(io_rd || io_wr));

  a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
    $countones({ram_re, ram_we, io_stb}) <= 1);

  a_r6_write_marks_page: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> dirty[$past(wr_page)]);

  a_r6_dirty_sticky: assert property (@(posedge clk) disable iff (rst)
    !dirty_clr |=> ((dirty & $past(dirty)) == $past(dirty)));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
    (dirty_clr && !cpu_wr) |=> (dirty == '0));

  a_r9_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cpu_rvalid) |-> $past(ram_re || (io_stb && io_rd)));

  a_r5_write_needs_request: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (ram_we || io_wr)) |-> $past(cpu_wr));

  a_r4_io_write_in_window: assert property (@(posedge clk) disable iff (rst)
    (past_ok && io_wr) |-> $past(in_io));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_wr) |=> (!ram_re && !io_rd));

  a_r2_io_read_slot: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && in_io) |=> (io_stb && io_rd && io_slot == $past(req_slot)));

endmodule

bind pmr_router pmr_router_chk #(
  .ADDR_W  (ADDR_W),
  .OFF_W   (OFF_W),
  .IO_TAG_W(IO_TAG_W),
  .IO_TAG  (IO_TAG),
  .SLOT_W  (SLOT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rvalid(cpu_rvalid),
  .ram_re    (ram_re),
  .ram_we    (ram_we),
  .io_stb    (io_stb),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_slot   (io_slot),
  .dirty_clr (dirty_clr),
  .dirty     (dirty)
);

// File: tb/test_pmr_router.sv
`timescale 1ns/1ps
module test_pmr_router;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  cpu_addr = '0;
  logic [7:0]   cpu_wdata = '0;
  logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]   cpu_rdata;
  logic         cpu_rvalid;
  logic         cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [7:0]   cfg_page = '0, cfg_target = '0;
  logic         ram_re, ram_we;
  logic [15:0]  ram_addr;
  logic [7:0]   ram_wdata, ram_rdata;
  logic         io_stb, io_rd, io_wr;
  logic [7:0]   io_slot, io_wdata, io_rdata;
  logic         dirty_clr = 1'b0;
  logic [255:0] dirty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram_model(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h3C;
  endfunction

  assign ram_rdata = ram_model(ram_addr);
  assign io_rdata  = ~io_slot;

  pmr_router i_pmr_router (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with strobes released.
  task automatic op(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] pg, input logic v, input logic [7:0] t);
    cfg_we = 1'b1; cfg_page = pg; cfg_valid = v; cfg_target = t;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Vector: {wr, addr, data, kind, eaddr}; kind 0 dropped, 1 RAM, 2 I/O (eaddr[7:0] = slot)
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 16'h2034, 8'h5A, 2'd1, 16'h8034},  // R3 remapped page
    {1'b1, 16'hC0A7, 8'hA5, 2'd2, 16'h000A},  // R4 I/O write
    {1'b1, 16'hC3F1, 8'h11, 2'd1, 16'h11F1},  // R3 mapped page inside I/O window
    {1'b1, 16'hD012, 8'h99, 2'd0, 16'h0000},  // R5 read-only page
    {1'b0, 16'h2034, 8'h00, 2'd1, 16'h2034},  // R2 RAM read, untranslated
    {1'b0, 16'hC5B0, 8'h00, 2'd2, 16'h005B},  // R2 I/O read slot
    {1'b0, 16'hD012, 8'h00, 2'd1, 16'hD012},  // R2 RAM read of read-only page
    {1'b1, 16'h0005, 8'h42, 2'd1, 16'h0005}   // R3 identity page
  };

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(dirty == '0, "R1 dirty", dirty[63:0], 0);
    chk({ram_re, ram_we, io_stb, io_rd, io_wr, cpu_rvalid} == 6'b0, "R1 strobes",
        {ram_re, ram_we, io_stb, io_rd, io_wr, cpu_rvalid}, 0);

    // R1 table invalid after reset: write to page 0x20 is dropped; R6 still marks it
    op(1'b1, 1'b0, 16'h2034, 8'h01);
    chk(!ram_we && !io_stb, "R1 table invalid", {ram_we, io_stb}, 0);
    chk(dirty[8'h20], "R6 dropped write marks page", dirty[8'h20], 1);
    dirty_clr = 1'b1; @(negedge clk); dirty_clr = 1'b0;
    chk(dirty == '0, "R7 clear", dirty[63:0], 0);

    // R10 table load
    cfg(8'h20, 1'b1, 8'h80);
    cfg(8'hC3, 1'b1, 8'h11);
    cfg(8'h00, 1'b1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic        wr;
      logic [15:0] a, ea;
      logic [7:0]  d;
      logic [1:0]  k;
      {wr, a, d, k, ea} = VEC[i];
      op(wr, ~wr, a, d);
      if (k == 2'd0) begin
        chk(!ram_we && !ram_re && !io_stb, "R5 dropped write", {ram_re, ram_we, io_stb}, 0);
      end else if (k == 2'd1) begin
        if (wr) chk(ram_we && !io_stb && ram_addr == ea && ram_wdata == d, "R3 RAM write",
                    {ram_we, ram_addr, ram_wdata}, {1'b1, ea, d});
        else    chk(ram_re && !io_stb && ram_addr == ea, "R2 RAM read",
                    {ram_re, ram_addr}, {1'b1, ea});
      end else begin
        if (wr) chk(io_stb && io_wr && !io_rd && io_slot == ea[7:0] && io_wdata == d, "R4 I/O write",
                    {io_stb, io_wr, io_slot, io_wdata}, {2'b11, ea[7:0], d});
        else    chk(io_stb && io_rd && !io_wr && io_slot == ea[7:0], "R2 I/O read",
                    {io_stb, io_rd, io_slot}, {2'b11, ea[7:0]});
      end
      if (wr) chk(dirty[a[15:8]], "R6 write marks page", dirty[a[15:8]], 1);
      @(negedge clk);
      chk(!io_stb && !ram_re && !ram_we, "R8 one-cycle strobe", {io_stb, ram_re, ram_we}, 0);
      if (!wr) begin
        logic [7:0] er;
        er = (k == 2'd1) ? ram_model(ea) : ~ea[7:0];
        chk(cpu_rvalid && cpu_rdata == er, "R9 read data", {cpu_rvalid, cpu_rdata}, {1'b1, er});
      end else begin
        chk(!cpu_rvalid, "R9 no rvalid on write", cpu_rvalid, 0);
      end
    end
    // R6: pages 20, C0, C3, D0, 00 written; reads mark nothing
    chk($countones(dirty) == 5, "R6 dirty count", $countones(dirty), 5);

    // R7: clear racing a write
    dirty_clr = 1'b1;
    op(1'b1, 1'b0, 16'h4501, 8'h00);
    dirty_clr = 1'b0;
    chk(dirty == (256'd1 << 8'h45), "R7 clear loses to set", dirty[127:0], 128'd1 << 8'h45);

    // R10: same-cycle config and write uses the old (invalid) entry
    cfg_we = 1'b1; cfg_page = 8'h50; cfg_valid = 1'b1; cfg_target = 8'h66;
    op(1'b1, 1'b0, 16'h5010, 8'h33);
    cfg_we = 1'b0;
    chk(!ram_we && !io_stb, "R10 old entry used", {ram_we, io_stb}, 0);
    op(1'b1, 1'b0, 16'h5010, 8'h34);
    chk(ram_we && ram_addr == 16'h6610 && ram_wdata == 8'h34, "R10 new entry",
        {ram_we, ram_addr}, {1'b1, 16'h6610});
    cfg(8'h50, 1'b0, 8'h66);
    op(1'b1, 1'b0, 16'h5010, 8'h35);
    chk(!ram_we && !io_stb, "R10 invalidated entry", {ram_we, io_stb}, 0);

    // R11: read and write together
    op(1'b1, 1'b1, 16'h2040, 8'h77);
    chk(ram_we && !ram_re && ram_addr == 16'h8040, "R11 write performed",
        {ram_we, ram_re, ram_addr}, {2'b10, 16'h8040});
    @(negedge clk);
    chk(!cpu_rvalid, "R11 no read response", cpu_rvalid, 0);

    // R8/R9: back-to-back I/O then RAM reads
    op(1'b0, 1'b1, 16'hCFF0, 8'h00);
    chk(io_stb && io_rd && io_slot == 8'hFF, "R8 I/O read port", {io_stb, io_slot}, {1'b1, 8'hFF});
    op(1'b0, 1'b1, 16'h1234, 8'h00);
    chk(cpu_rvalid && cpu_rdata == 8'h00, "R9 I/O read data", cpu_rdata, 8'h00);
    chk(ram_re && !io_stb && ram_addr == 16'h1234, "R8 RAM read port", {ram_re, io_stb}, 2'b10);
    @(negedge clk);
    chk(cpu_rvalid && cpu_rdata == ram_model(16'h1234), "R9 RAM read data",
        cpu_rdata, ram_model(16'h1234));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule